// File: doc/BRIEF.md
# Prioritized Command Queue Scheduler

This block holds several small command FIFOs and moves their contents to a set of destination buffers. The buffers stand in front of two on-chip converters and one external device. Software fills a FIFO with 32-bit commands and then writes a control word. The control word sets the FIFO's operating mode and can fire its start strobe. When the mode is software-triggered single-scan, the strobe arms the FIFO. From then on the scheduler offers the FIFO's commands, one at a time and in push order, to the buffer that each command names.

Several armed FIFOs may compete for one buffer. The lowest-numbered FIFO wins, but only at a command boundary: a command that is already being offered is never withdrawn. FIFOs that target different buffers move in parallel. A command with its end-of-queue bit set closes the scan of its FIFO. It also raises that FIFO's sticky completion flag, which feeds a maskable interrupt. A single control write covers a pair of FIFOs, so two queues can be configured and started in the same cycle.

Top module: `cmd_queue_sched`

## Requirements
- R1: In a control half-word, bits 7:4 are the mode and bit 10 is the start strobe. A write with mode 4'b0001 and the strobe set makes that FIFO's scan_active bit 1 after the write's clock edge.
- R2: A control write to pair p sets FIFO 2p from bits 31:16 and FIFO 2p+1 from bits 15:0. Both FIFOs are configured and started on the same edge.
- R3: ctrl_rdata returns the stored modes of the selected pair, in bits 7:4 of each half. Every other bit reads 0, including the start strobe.
- R4: Command bits 25:24 select the destination buffer, 0 to 2. A command whose select is 3 is consumed without appearing on any buffer.
- R5: When armed FIFOs compete for one buffer, the lowest-numbered FIFO is served first at each command boundary.
- R6: Armed FIFOs that target different buffers transfer in the same cycle.
- R7: While buf_valid is high and buf_ready is low, the offered command stays unchanged. A higher-priority FIFO armed meanwhile does not replace it.
- R8: Command bit 31 marks end of queue. Once such a command is transferred, the FIFO leaves scan mode and its eoq_flag bit sets. Commands left behind it are not issued.
- R9: Writing 1 to an eoq_clr bit clears only that flag. irq is high exactly when some flag is set whose irq_en bit is 1.
- R10: A start strobe to a FIFO that is already scanning is ignored and does not re-arm the FIFO after it completes. A strobe with mode 4'b0000 does not start a scan.
- R11: Each FIFO issues its commands in push order. push_ready is low when the FIFO selected by push_fifo is full, and a push into a full FIFO is dropped.
- R12: After reset, all FIFOs are empty and idle, and no flags are set. irq, buf_valid and ctrl_rdata are 0, and push_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a command into a FIFO |
| push_fifo | input | 2 | Index of the FIFO to push into |
| push_cmd | input | 32 | Command word to push |
| push_ready | output | 1 | The selected FIFO has room |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_pair | input | 1 | FIFO pair addressed by the control write and the readback |
| ctrl_wdata | input | 32 | Control word: two half-words, one per FIFO |
| ctrl_rdata | output | 32 | Mode readback for the selected pair |
| eoq_clr | input | 4 | Write-1-to-clear for the end-of-queue flags |
| irq_en | input | 4 | Interrupt enable, one bit per FIFO |
| scan_active | output | 4 | FIFO is armed in single-scan operation |
| eoq_flag | output | 4 | Sticky end-of-queue flags |
| irq | output | 1 | End-of-queue interrupt |
| buf_valid | output | 3 | A command is offered to the buffer |
| buf_ready | input | 3 | The buffer accepts the offered command |
| buf_cmd | output | 96 | Offered command, 32 bits per buffer, buffer 0 in the low bits |

## Verification
The bench builds the block at its defaults: four FIFOs of depth four and three buffers. With these values, two FIFO pairs exercise both halves of the control word. A FIFO can be filled to its limit with a handful of pushes, and the unused select value 3 is available for the discard path. Contention is produced by holding a buffer's ready low while a lower-numbered FIFO is armed behind a stalled offer.

// File: rtl/cqs_pkg.sv
`timescale 1ns/1ps
package cqs_pkg;
    localparam int CMD_W     = 32;
    localparam int EOQ_BIT   = 31;
    localparam int BSEL_LSB  = 24;
    localparam int BSEL_W    = 2;
    localparam int HALF_W    = 16;
    localparam int START_BIT = 10;
    localparam int MODE_LSB  = 4;
    localparam int MODE_W    = 4;

    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_SW_SINGLE = 4'b0001;

    function automatic logic cmd_is_eoq(cmd_t c);
        return c[EOQ_BIT];
    endfunction

    function automatic logic [BSEL_W-1:0] cmd_bsel(cmd_t c);
        return c[BSEL_LSB +: BSEL_W];
    endfunction
endpackage

// File: rtl/cqs_fifo.sv
`timescale 1ns/1ps
module cqs_fifo
    import cqs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cmd_t wr_data,
    input  logic rd_en,
    output cmd_t rd_data,
    output logic empty,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        cmd_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic do_wr, do_rd;

    assign empty   = (s_q.count == '0);
    assign full    = (s_q.count == CNT_W'(DEPTH));
    assign rd_data = s_q.mem[s_q.rptr];

    always_comb begin
        s_d   = s_q;
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        if (do_wr) begin
            s_d.mem[s_q.wptr] = wr_data;
            s_d.wptr = (s_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (do_rd) begin
            s_d.rptr = (s_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : s_q.rptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   s_d.count = s_q.count + CNT_W'(1);
            2'b01:   s_d.count = s_q.count - CNT_W'(1);
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R11: a push into a full FIFO leaves its contents and write pointer alone
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> full && $stable(s_q.wptr));
endmodule

// File: rtl/cqs_ctrl.sv
`timescale 1ns/1ps
module cqs_ctrl
    import cqs_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int PAIR_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [PAIR_W-1:0]   ctrl_pair,
    input  logic [31:0]         ctrl_wdata,
    input  logic [NUM_FIFO-1:0] done,
    input  logic [NUM_FIFO-1:0] eoq_clr,
    input  logic [NUM_FIFO-1:0] irq_en,
    output logic [NUM_FIFO-1:0] active,
    output logic [NUM_FIFO-1:0] eoq_flag,
    output logic                irq,
    output logic [31:0]         ctrl_rdata
);
    localparam int NUM_PAIR = NUM_FIFO / 2;

    typedef struct packed {
        mode_t [NUM_FIFO-1:0] mode;
        logic  [NUM_FIFO-1:0] active;
        logic  [NUM_FIFO-1:0] eoq;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic [NUM_FIFO-1:0] trig;
    logic unused_wdata;

    assign unused_wdata = ^ctrl_wdata;

    always_comb begin
        s_d  = s_q;
        trig = '0;
        for (int i = 0; i < NUM_FIFO; i++) begin
            int base;
            base = (i % 2 == 0) ? HALF_W : 0;
            if (ctrl_wr && ctrl_pair == PAIR_W'(i / 2)) begin
                s_d.mode[i] = ctrl_wdata[base + MODE_LSB +: MODE_W];
                trig[i]     = ctrl_wdata[base + START_BIT];
            end
            if (done[i]) s_d.active[i] = 1'b0;
            if (trig[i] && !s_q.active[i] && s_d.mode[i] == MODE_SW_SINGLE)
                s_d.active[i] = 1'b1;
            if (eoq_clr[i]) s_d.eoq[i] = 1'b0;
            if (done[i])    s_d.eoq[i] = 1'b1;
        end
    end

    always_comb begin
        ctrl_rdata = '0;
        for (int p = 0; p < NUM_PAIR; p++) begin
            if (ctrl_pair == PAIR_W'(p)) begin
                ctrl_rdata[HALF_W + MODE_LSB +: MODE_W] = s_q.mode[2*p];
                ctrl_rdata[MODE_LSB +: MODE_W]          = s_q.mode[2*p+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active   = s_q.active;
    assign eoq_flag = s_q.eoq;
    assign irq      = |(s_q.eoq & irq_en);

    // R8: a completed queue always leaves its flag set on the next cycle
    a_r8_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        |done |=> ((s_q.eoq & $past(done)) == $past(done)));

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_chk
        // R10: an idle FIFO only starts on a strobe
        a_r10_start_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.active[g] && !trig[g] |=> !s_q.active[g]);
        // R10: a strobe with a mode other than single-scan leaves it idle
        a_r10_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.active[g] && trig[g] && s_d.mode[g] != MODE_SW_SINGLE |=> !s_q.active[g]);
    end
endmodule

// File: rtl/cqs_arb.sv
`timescale 1ns/1ps
module cqs_arb #(
    parameter int NUM_FIFO = 4,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FIFO-1:0] req,
    input  logic                ready,
    output logic                valid,
    output logic [NUM_FIFO-1:0] gnt,
    output logic [IDX_W-1:0]    sel
);
    typedef struct packed {
        logic             locked;
        logic [IDX_W-1:0] owner;
    } arb_st_t;

    arb_st_t s_d, s_q;
    logic [IDX_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NUM_FIFO - 1; i >= 0; i--) begin
            if (req[i]) pick = IDX_W'(i);
        end
        if (s_q.locked) begin
            sel   = s_q.owner;
            valid = 1'b1;
        end else begin
            sel   = pick;
            valid = |req;
        end
        gnt = '0;
        if (valid) gnt[sel] = 1'b1;
        s_d.locked = valid && !ready;
        s_d.owner  = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: at most one FIFO holds the buffer
    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R7: a stalled offer keeps its owner
    a_r7_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && sel == $past(sel));
endmodule

// File: rtl/cmd_queue_sched.sv
`timescale 1ns/1ps
module cmd_queue_sched
    import cqs_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 4,
    parameter int NUM_BUF  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_valid,
    input  logic [$clog2(NUM_FIFO)-1:0] push_fifo,
    input  logic [31:0]              push_cmd,
    output logic                     push_ready,
    input  logic                     ctrl_wr,
    input  logic [((NUM_FIFO > 2) ? $clog2(NUM_FIFO/2) : 1)-1:0] ctrl_pair,
    input  logic [31:0]              ctrl_wdata,
    output logic [31:0]              ctrl_rdata,
    input  logic [NUM_FIFO-1:0]      eoq_clr,
    input  logic [NUM_FIFO-1:0]      irq_en,
    output logic [NUM_FIFO-1:0]      scan_active,
    output logic [NUM_FIFO-1:0]      eoq_flag,
    output logic                     irq,
    output logic [NUM_BUF-1:0]       buf_valid,
    input  logic [NUM_BUF-1:0]       buf_ready,
    output logic [NUM_BUF*32-1:0]    buf_cmd
);
    localparam int IDX_W  = $clog2(NUM_FIFO);
    localparam int PAIR_W = (NUM_FIFO > 2) ? $clog2(NUM_FIFO / 2) : 1;

    cmd_t                head [NUM_FIFO];
    logic [NUM_FIFO-1:0] empty, full, pop, done, discard;
    logic [NUM_FIFO-1:0] req  [NUM_BUF];
    logic [NUM_FIFO-1:0] gnt  [NUM_BUF];
    logic [IDX_W-1:0]    sel  [NUM_BUF];

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
        cqs_fifo #(.DEPTH(DEPTH)) fifo_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (push_valid && push_fifo == IDX_W'(g)),
            .wr_data (push_cmd),
            .rd_en   (pop[g]),
            .rd_data (head[g]),
            .empty   (empty[g]),
            .full    (full[g])
        );
    end

    assign push_ready = !full[push_fifo];

    cqs_ctrl #(.NUM_FIFO(NUM_FIFO), .PAIR_W(PAIR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_pair  (ctrl_pair),
        .ctrl_wdata (ctrl_wdata),
        .done       (done),
        .eoq_clr    (eoq_clr),
        .irq_en     (irq_en),
        .active     (scan_active),
        .eoq_flag   (eoq_flag),
        .irq        (irq),
        .ctrl_rdata (ctrl_rdata)
    );

    // Routing: an armed, non-empty FIFO requests the buffer its head names
    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) req[b] = '0;
        discard = '0;
        for (int i = 0; i < NUM_FIFO; i++) begin
            logic elig;
            logic [BSEL_W-1:0] bs;
            elig = scan_active[i] && !empty[i];
            bs   = cmd_bsel(head[i]);
            discard[i] = elig && (int'(bs) >= NUM_BUF);
            for (int b = 0; b < NUM_BUF; b++) begin
                req[b][i] = elig && (bs == BSEL_W'(b));
            end
        end
    end

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        cqs_arb #(.NUM_FIFO(NUM_FIFO), .IDX_W(IDX_W)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[b]),
            .ready (buf_ready[b]),
            .valid (buf_valid[b]),
            .gnt   (gnt[b]),
            .sel   (sel[b])
        );
        assign buf_cmd[b*32 +: 32] = head[sel[b]];

        // R7: a stalled offer does not change
        a_r7_stable_offer: assert property (@(posedge clk) disable iff (!rst_n)
            buf_valid[b] && !buf_ready[b] |=> buf_valid[b] && $stable(buf_cmd[b*32 +: 32]));
        // R4: every offered command names the buffer it appears on
        a_r4_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
            buf_valid[b] |-> buf_cmd[b*32 + BSEL_LSB +: BSEL_W] == BSEL_W'(b));
    end

    always_comb begin
        pop = discard;
        for (int b = 0; b < NUM_BUF; b++) begin
            if (buf_valid[b] && buf_ready[b]) pop = pop | gnt[b];
        end
        for (int i = 0; i < NUM_FIFO; i++) begin
            done[i] = pop[i] && cmd_is_eoq(head[i]);
        end
    end

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_irq_chk
        // R9: an enabled flag always reaches the interrupt
        a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            eoq_flag[g] && irq_en[g] |-> irq);
    end
endmodule

// File: tb/cmd_queue_sched_tb_top.sv
`timescale 1ns/1ps
module cmd_queue_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [1:0]  push_fifo = '0;
    logic [31:0] push_cmd = '0;
    logic        push_ready;
    logic        ctrl_wr = 1'b0;
    logic [0:0]  ctrl_pair = '0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [3:0]  eoq_clr = '0;
    logic [3:0]  irq_en = '0;
    logic [3:0]  scan_active;
    logic [3:0]  eoq_flag;
    logic        irq;
    logic [2:0]  buf_valid;
    logic [2:0]  buf_ready = '0;
    logic [95:0] buf_cmd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] log_tag [3][64];
    int         log_cyc [3][64];
    int         cnt     [3];

    always #4 clk = ~clk;

    cmd_queue_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_fifo(push_fifo), .push_cmd(push_cmd),
        .push_ready(push_ready),
        .ctrl_wr(ctrl_wr), .ctrl_pair(ctrl_pair), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata),
        .eoq_clr(eoq_clr), .irq_en(irq_en),
        .scan_active(scan_active), .eoq_flag(eoq_flag), .irq(irq),
        .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_cmd(buf_cmd)
    );

    initial begin
        for (int b = 0; b < 3; b++) cnt[b] = 0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int b = 0; b < 3; b++) begin
            if (rst_n && buf_valid[b] && buf_ready[b] && cnt[b] < 64) begin
                log_tag[b][cnt[b]] = buf_cmd[b*32 +: 8];
                log_cyc[b][cnt[b]] = cyc;
                cnt[b] = cnt[b] + 1;
            end
        end
    end

    function automatic logic [31:0] mk(input logic eoq, input logic [1:0] bsel, input logic [7:0] tag);
        return {eoq, 5'b0, bsel, 16'h0, tag};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] f, input logic [31:0] c);
        push_valid = 1'b1;
        push_fifo  = f;
        push_cmd   = c;
        tick();
        push_valid = 1'b0;
    endtask

    task automatic ctrl_write(input logic p, input logic [31:0] d);
        ctrl_wr    = 1'b1;
        ctrl_pair  = p;
        ctrl_wdata = d;
        tick();
        ctrl_wr    = 1'b0;
    endtask

    task automatic clear_flags(input logic [3:0] m);
        eoq_clr = m;
        tick();
        eoq_clr = '0;
    endtask

    task automatic t_reset();
        chk(buf_valid == 3'b000, "R12 buf_valid after reset", 32'(buf_valid), 0);
        chk(scan_active == 4'b0, "R12 scan_active after reset", 32'(scan_active), 0);
        chk(eoq_flag == 4'b0 && irq == 1'b0, "R12 flags/irq after reset", 32'({eoq_flag, irq}), 0);
        chk(push_ready == 1'b1, "R12 push_ready after reset", 32'(push_ready), 1);
        chk(ctrl_rdata == 32'h0, "R12 ctrl_rdata after reset", ctrl_rdata, 0);
    endtask

    task automatic t_single();
        int b0;
        buf_ready = 3'b111;
        push(2'd0, mk(1'b0, 2'd0, 8'h01));
        push(2'd0, mk(1'b0, 2'd0, 8'h02));
        push(2'd0, mk(1'b1, 2'd0, 8'h03));
        b0 = cnt[0];
        ctrl_write(1'b0, 32'h0410_0000);
        chk(scan_active[0] == 1'b1, "R1 FIFO0 armed by strobe", 32'(scan_active), 1);
        idle(6);
        chk(cnt[0] - b0 == 3, "R11 three commands issued", 32'(cnt[0] - b0), 3);
        chk(log_tag[0][b0] == 8'h01 && log_tag[0][b0+1] == 8'h02 && log_tag[0][b0+2] == 8'h03,
            "R11 push order kept", {8'h0, log_tag[0][b0], log_tag[0][b0+1], log_tag[0][b0+2]}, 32'h010203);
        chk(eoq_flag == 4'b0001 && scan_active[0] == 1'b0, "R8 flag set, scan ended",
            32'({eoq_flag, scan_active}), 32'h10);
        chk(irq == 1'b0, "R9 masked flag gives no irq", 32'(irq), 0);
        irq_en = 4'b0001;
        #1;
        chk(irq == 1'b1, "R9 enabled flag raises irq", 32'(irq), 1);
        clear_flags(4'b0001);
        chk(eoq_flag == 4'b0 && irq == 1'b0, "R9 flag cleared by write-1", 32'({eoq_flag, irq}), 0);
        irq_en = 4'b0000;
    endtask

    task automatic t_pair();
        int b0, b1;
        buf_ready = 3'b111;
        push(2'd0, mk(1'b0, 2'd0, 8'h11));
        push(2'd0, mk(1'b1, 2'd0, 8'h12));
        push(2'd1, mk(1'b0, 2'd1, 8'h21));
        push(2'd1, mk(1'b1, 2'd1, 8'h22));
        b0 = cnt[0];
        b1 = cnt[1];
        ctrl_write(1'b0, 32'h0410_0410);
        chk(scan_active[1:0] == 2'b11, "R2 both FIFOs of the pair armed", 32'(scan_active), 3);
        chk(ctrl_rdata == 32'h0010_0010, "R3 readback hides strobe", ctrl_rdata, 32'h0010_0010);
        idle(6);
        chk(cnt[0] - b0 == 2 && log_tag[0][b0] == 8'h11 && log_tag[0][b0+1] == 8'h12,
            "R4 FIFO0 to buffer 0", {log_tag[0][b0], log_tag[0][b0+1]}, 32'h1112);
        chk(cnt[1] - b1 == 2 && log_tag[1][b1] == 8'h21 && log_tag[1][b1+1] == 8'h22,
            "R4 FIFO1 to buffer 1", {log_tag[1][b1], log_tag[1][b1+1]}, 32'h2122);
        chk(log_cyc[0][b0] == log_cyc[1][b1], "R6 parallel transfer same cycle",
            32'(log_cyc[1][b1]), 32'(log_cyc[0][b0]));
        chk(eoq_flag == 4'b0011, "R8 both flags set", 32'(eoq_flag), 3);
        clear_flags(4'b0001);
        chk(eoq_flag == 4'b0010, "R9 only selected flag cleared", 32'(eoq_flag), 2);
        clear_flags(4'b0010);
    endtask

    task automatic t_contend();
        int b0;
        buf_ready = 3'b000;
        push(2'd1, mk(1'b0, 2'd0, 8'h31));
        push(2'd1, mk(1'b1, 2'd0, 8'h32));
        push(2'd0, mk(1'b0, 2'd0, 8'h41));
        push(2'd0, mk(1'b1, 2'd0, 8'h42));
        b0 = cnt[0];
        ctrl_write(1'b0, 32'h0010_0410);
        chk(buf_valid[0] == 1'b1 && buf_cmd[7:0] == 8'h31, "R5 lone FIFO1 offered",
            32'(buf_cmd[7:0]), 32'h31);
        ctrl_write(1'b0, 32'h0410_0010);
        idle(1);
        chk(buf_valid[0] == 1'b1 && buf_cmd[7:0] == 8'h31, "R7 stalled offer kept",
            32'(buf_cmd[7:0]), 32'h31);
        buf_ready = 3'b001;
        idle(6);
        chk(cnt[0] - b0 == 4, "R5 four commands issued", 32'(cnt[0] - b0), 4);
        chk(log_tag[0][b0] == 8'h31 && log_tag[0][b0+1] == 8'h41 &&
            log_tag[0][b0+2] == 8'h42 && log_tag[0][b0+3] == 8'h32,
            "R5 lower FIFO wins at boundary",
            {log_tag[0][b0], log_tag[0][b0+1], log_tag[0][b0+2], log_tag[0][b0+3]}, 32'h31414232);
        clear_flags(4'b0011);
    endtask

    task automatic t_discard();
        int b0, b1, b2;
        buf_ready = 3'b111;
        push(2'd2, mk(1'b0, 2'd3, 8'h51));
        push(2'd2, mk(1'b1, 2'd2, 8'h52));
        b0 = cnt[0];
        b1 = cnt[1];
        b2 = cnt[2];
        ctrl_write(1'b1, 32'h0410_0000);
        idle(6);
        chk(cnt[2] - b2 == 1 && log_tag[2][b2] == 8'h52, "R4 buffer 2 gets only valid select",
            32'(cnt[2] - b2), 1);
        chk(cnt[0] == b0 && cnt[1] == b1, "R4 select 3 reaches no buffer",
            32'(cnt[0] - b0 + cnt[1] - b1), 0);
        chk(eoq_flag == 4'b0100, "R8 FIFO2 flag", 32'(eoq_flag), 4);
        clear_flags(4'b0100);
    endtask

    task automatic t_ignore_and_full();
        int b1;
        buf_ready = 3'b101;
        push(2'd3, mk(1'b0, 2'd1, 8'h61));
        push(2'd3, mk(1'b1, 2'd1, 8'h62));
        push(2'd3, mk(1'b0, 2'd1, 8'h63));
        b1 = cnt[1];
        ctrl_write(1'b1, 32'h0000_0410);
        idle(1);
        ctrl_write(1'b1, 32'h0000_0410);
        buf_ready = 3'b111;
        idle(8);
        chk(cnt[1] - b1 == 2 && log_tag[1][b1] == 8'h61 && log_tag[1][b1+1] == 8'h62,
            "R8 nothing issued past end of queue", 32'(cnt[1] - b1), 2);
        chk(scan_active[3] == 1'b0 && buf_valid[1] == 1'b0, "R10 retrigger did not re-arm",
            32'({scan_active[3], buf_valid[1]}), 0);
        clear_flags(4'b1000);
        ctrl_write(1'b1, 32'h0000_0400);
        idle(3);
        chk(scan_active[3] == 1'b0 && buf_valid[1] == 1'b0, "R10 strobe with mode 0 ignored",
            32'({scan_active[3], buf_valid[1]}), 0);
        chk(ctrl_rdata == 32'h0, "R3 mode 0 reads back as 0", ctrl_rdata, 0);
        push(2'd3, mk(1'b0, 2'd1, 8'h71));
        push(2'd3, mk(1'b0, 2'd1, 8'h72));
        push(2'd3, mk(1'b1, 2'd1, 8'h73));
        push_fifo = 2'd3;
        #1;
        chk(push_ready == 1'b0, "R11 full FIFO drops ready", 32'(push_ready), 0);
        push(2'd3, mk(1'b0, 2'd1, 8'h74));
        b1 = cnt[1];
        ctrl_write(1'b1, 32'h0000_0410);
        idle(8);
        chk(cnt[1] - b1 == 4 && log_tag[1][b1] == 8'h63 && log_tag[1][b1+3] == 8'h73,
            "R11 push into full FIFO dropped", 32'(cnt[1] - b1), 4);
        push_fifo = 2'd3;
        #1;
        chk(push_ready == 1'b1, "R11 ready back after drain", 32'(push_ready), 1);
        clear_flags(4'b1000);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_single();
        t_pair();
        t_contend();
        t_discard();
        t_ignore_and_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule